// File: doc/BRIEF.md
# Control-Line Edge Interrupt Latch

This block watches a single external control input for a chosen transition and turns that momentary event into a held interrupt request. The input is first brought into the clock domain through a chain of flip-flops. The current synchronised sample is then compared with the previous one, and an edge of the selected polarity is recorded in a pending flag. The flag drives an active-low interrupt request line whenever the enable bit is set. The request stays asserted until software acknowledges it.

Software talks to the block through two byte-wide registers, chosen by one address bit. One is a control register and the other is a data port. A read of the data port acknowledges the interrupt as a side effect. This means any data port read drops a pending request, even if the reader did not intend to acknowledge it. A read of the control register has no side effect. Writes to the data port drive an output byte. Reads of the data port return an input byte.

The pending flag is held in a two-state machine:
- `FLAG_IDLE` moves to `FLAG_PENDING` on transition *capture* (an active edge is seen).
- `FLAG_PENDING` returns to `FLAG_IDLE` on transition *acknowledge* (a data port read with no active edge in the same cycle).
- `FLAG_PENDING` stays put on *re-arm* (an acknowledge and an active edge in the same cycle).
- `FLAG_IDLE` stays put on *quiet* (no active edge).

Top module: `ctl_irq_latch`

## Requirements
- R1: After reset, the control readback is 0x00, the pending flag is 0 and `irq_n` is 1.
- R2: Control register (address 1) bits 5..0 are read/write. On readback, bit 7 is the pending flag and bit 6 is always 0. Writes to bits 7 and 6 have no effect.
- R3: With control bit 4 = 1, a rising edge on `ctl_line` sets the flag. With bit 4 = 0, a falling edge sets it. The opposite edge leaves the flag unchanged.
- R4: With control bit 5 = 1, the control line is not an interrupt input, and no edge sets the flag.
- R5: `irq_n` is 0 exactly when the flag is 1 and control bit 3 is 1. Clearing bit 3 releases `irq_n` but keeps the flag at 1.
- R6: A read strobe at address 0 (data port) clears the flag and releases `irq_n`. A read at address 1 does not clear the flag. Once captured, the flag stays set after the control line returns to its idle level.
- R7: If an active edge is detected in the same cycle as a data port read, the flag remains 1.
- R8: A change on `ctl_line` sets the flag on the third rising clock edge after it is applied, and not on the second.
- R9: A data port read returns `port_in`. A data port write drives `port_out` from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_line | input | 1 | Asynchronous control input being watched |
| addr | input | 1 | Register select: 0 data port, 1 control |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (data port read acknowledges) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| port_in | input | 8 | Byte returned by data port reads |
| port_out | output | 8 | Byte last written to the data port |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The tests drive the control line in several ways:
- Single rising and falling transitions under both polarity settings, which separate the selected edge from the ignored one.
- Short pulses that return to idle, which show that a captured event is held as a level.
- Transitions while the line is in non-interrupt mode, which separate that mode from interrupt mode.

The tests also exercise the acknowledge path. Reads at each address show that only the data port clears the flag. A read placed exactly in the cycle the edge is detected shows that the re-arm transition keeps a new event. Cycle-exact sampling after a transition confirms the synchroniser latency.

// File: rtl/ctl_irq_pkg.sv
package ctl_irq_pkg;
    // Control register bit positions; software decodes these, so they are fixed.
    localparam int unsigned BIT_FLAG   = 7;
    localparam int unsigned BIT_MODE   = 5;
    localparam int unsigned BIT_POL    = 4;
    localparam int unsigned BIT_IRQEN  = 3;
    localparam int unsigned CTRL_RW_W  = 6;

    localparam logic ADDR_DATA = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;

    typedef enum logic [0:0] {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;
endpackage

// File: rtl/ctl_line_sync.sv
module ctl_line_sync #(
    parameter int unsigned STAGES     = 2,
    parameter logic        IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sample_now,
    output logic sample_prev
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gi] <= IDLE_LEVEL;
                    else        chain_q[gi] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[gi] <= IDLE_LEVEL;
                    else        chain_q[gi] <= chain_q[gi-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= IDLE_LEVEL;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign sample_now  = chain_q[STAGES-1];
    assign sample_prev = prev_q;
endmodule

// File: rtl/ctl_edge_pick.sv
module ctl_edge_pick (
    input  logic sample_now,
    input  logic sample_prev,
    input  logic pol_rise,
    input  logic mode_other,
    output logic edge_hit
);
    logic rise_seen;
    logic fall_seen;

    always_comb begin
        rise_seen = sample_now & ~sample_prev;
        fall_seen = ~sample_now & sample_prev;
        edge_hit  = 1'b0;
        if (!mode_other) begin
            edge_hit = pol_rise ? rise_seen : fall_seen;
        end
    end
endmodule

// File: rtl/ctl_flag_fsm.sv
module ctl_flag_fsm
    import ctl_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_hit,
    input  logic ack,
    output logic flag
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:    if (edge_hit)       state_d = FLAG_PENDING;
            FLAG_PENDING: if (ack && !edge_hit) state_d = FLAG_IDLE;
            default:                          state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == FLAG_PENDING);
    end

    assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> flag);
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && ack && !edge_hit) |=> !flag);
    assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && edge_hit) |=> flag);
    assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_hit && !flag) |=> !flag);
endmodule

// File: rtl/ctl_irq_latch.sv
module ctl_irq_latch
    import ctl_irq_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic        IDLE_LEVEL  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_line,
    input  logic              addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] port_in,
    output logic [DATA_W-1:0] port_out,
    output logic              irq_n
);
    logic [CTRL_RW_W-1:0] ctrl_q;
    logic [DATA_W-1:0]    port_q;
    logic                 s_now;
    logic                 s_prev;
    logic                 edge_hit;
    logic                 ack;
    logic                 flag;
    logic                 unused_wr_hi;

    assign unused_wr_hi = ^wdata[DATA_W-1:CTRL_RW_W];

    ctl_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(IDLE_LEVEL)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (ctl_line),
        .sample_now (s_now),
        .sample_prev(s_prev)
    );

    ctl_edge_pick u_edge (
        .sample_now (s_now),
        .sample_prev(s_prev),
        .pol_rise   (ctrl_q[BIT_POL]),
        .mode_other (ctrl_q[BIT_MODE]),
        .edge_hit   (edge_hit)
    );

    assign ack = rd_en && (addr == ADDR_DATA);

    ctl_flag_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .edge_hit(edge_hit),
        .ack     (ack),
        .flag    (flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            port_q <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_CTRL) ctrl_q <= wdata[CTRL_RW_W-1:0];
            else                   port_q <= wdata;
        end
    end

    always_comb begin
        if (addr == ADDR_CTRL) begin
            rdata                   = '0;
            rdata[CTRL_RW_W-1:0]    = ctrl_q;
            rdata[BIT_FLAG]         = flag;
        end else begin
            rdata = port_in;
        end
        irq_n    = ~(flag & ctrl_q[BIT_IRQEN]);
        port_out = port_q;
    end

    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_CTRL) |=> (ctrl_q == $past(wdata[CTRL_RW_W-1:0])));
    assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[BIT_IRQEN] |-> irq_n);
    assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> flag);
endmodule

// File: tb/ctl_irq_latch_tb.sv
module ctl_irq_latch_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_line = 1'b1;
    logic       addr = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] port_in = 8'h00;
    logic [7:0] port_out;
    logic       irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ctl_irq_latch u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_line(ctl_line), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .port_in(port_in), .port_out(port_out), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_ctrl(input logic [7:0] v);
        @(negedge clk); addr = 1'b1; wdata = v; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // Side-effect-free look at the control readback (no strobe).
    task automatic peek_ctrl(output logic [7:0] v);
        addr = 1'b1; #1; v = rdata;
    endtask

    task automatic read_data(output logic [7:0] v);
        @(negedge clk); addr = 1'b0; rd_en = 1'b1; #1; v = rdata;
        @(negedge clk); rd_en = 1'b0; addr = 1'b1;
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        peek_ctrl(v);
        check("R1 ctrl readback", v, 8'h00);
        check("R1 irq_n", {7'b0, irq_n}, 8'h01);
    endtask

    task automatic t_ctrl_rw;
        logic [7:0] v;
        put_ctrl(8'hFF); peek_ctrl(v);
        check("R2 write FF ignores bits 7 6", v, 8'h3F);
        put_ctrl(8'h15); peek_ctrl(v);
        check("R2 write 15", v, 8'h15);
        put_ctrl(8'h00);
    endtask

    task automatic t_latency_falling;
        logic [7:0] v;
        put_ctrl(8'h08);              // falling edge, irq enabled
        @(negedge clk); ctl_line = 1'b0;
        @(negedge clk); @(negedge clk);  // two rising edges done
        peek_ctrl(v);
        check("R8 not set after two edges", v[7], 1'b0);
        @(negedge clk); peek_ctrl(v);
        check("R8 set after third edge", v[7], 1'b1);
        check("R5 irq_n low", {7'b0, irq_n}, 8'h00);
        ctl_line = 1'b1; settle(4);
        peek_ctrl(v);
        check("R6 flag held after line idles", v[7], 1'b1);
    endtask

    task automatic t_ack;
        logic [7:0] v;
        port_in = 8'hA5;
        addr = 1'b1; @(negedge clk); rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        peek_ctrl(v);
        check("R6 ctrl read keeps flag", v[7], 1'b1);
        put_ctrl(8'h00); peek_ctrl(v);
        check("R5 disable keeps flag", v[7], 1'b1);
        check("R5 disable releases irq", {7'b0, irq_n}, 8'h01);
        put_ctrl(8'h08);
        check("R5 re-enable asserts irq", {7'b0, irq_n}, 8'h00);
        read_data(v);
        check("R9 data read returns port_in", v, 8'hA5);
        peek_ctrl(v);
        check("R6 data read clears flag", v[7], 1'b0);
        check("R6 irq released", {7'b0, irq_n}, 8'h01);
    endtask

    task automatic t_polarity;
        logic [7:0] v;
        // falling selected, rising edge must not set
        ctl_line = 1'b0; settle(5); read_data(v);
        ctl_line = 1'b1; settle(5); peek_ctrl(v);
        check("R3 rising ignored when falling selected", v[7], 1'b0);
        put_ctrl(8'h18);              // rising selected
        ctl_line = 1'b0; settle(5); peek_ctrl(v);
        check("R3 falling ignored when rising selected", v[7], 1'b0);
        ctl_line = 1'b1; settle(1); ctl_line = 1'b0; settle(5); peek_ctrl(v);
        check("R3 rising pulse captured", v[7], 1'b1);
        read_data(v);
        ctl_line = 1'b1; settle(5); read_data(v);
        put_ctrl(8'h08);
    endtask

    task automatic t_mode;
        logic [7:0] v;
        put_ctrl(8'h28);              // non-interrupt mode, falling
        ctl_line = 1'b0; settle(5); ctl_line = 1'b1; settle(5);
        peek_ctrl(v);
        check("R4 mode bit blocks capture", v[7], 1'b0);
        check("R4 irq idle", {7'b0, irq_n}, 8'h01);
        put_ctrl(8'h08);
    endtask

    task automatic t_rearm;
        logic [7:0] v;
        ctl_line = 1'b0; settle(5);   // flag set
        ctl_line = 1'b1; settle(5);
        @(negedge clk); ctl_line = 1'b0;
        @(negedge clk); @(negedge clk);  // edge detected in next cycle
        addr = 1'b0; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        peek_ctrl(v);
        check("R7 coincident edge keeps flag", v[7], 1'b1);
        ctl_line = 1'b1; read_data(v); settle(4);
        peek_ctrl(v);
        check("R7 later ack clears", v[7], 1'b0);
    endtask

    task automatic t_port_write;
        @(negedge clk); addr = 1'b0; wdata = 8'h3C; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        check("R9 port_out updated", port_out, 8'h3C);
    endtask

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(2);
        t_reset();
        t_ctrl_rw();
        t_latency_falling();
        t_ack();
        t_polarity();
        t_mode();
        t_rearm();
        t_port_write();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule